// File: doc/BRIEF.md
# Givens Rotation CORDIC Pipeline

This block applies one plane (Givens) rotation to a pair of matrix rows that arrive one element pair per clock. It is a pipelined circular CORDIC with one micro-rotation per stage. The element pair marked with the start flag is handled in vectoring mode. Every stage picks the direction that moves its y operand towards zero and stores that choice. The y output of that pair ends near zero, and its x output holds the pair's magnitude multiplied by the CORDIC gain (about 1.6468).

Every later valid pair from the same two rows is rotated by the same angle. Each stage replays its stored direction bit, so the whole row pair turns through one rotation. A new start flag begins a new row pair. The start flag and the valid bit travel through the pipeline beside the data. A larger QR engine can therefore chain these units without any extra alignment logic.

The datapath widens the inputs by two guard bits, and the outputs keep that full width. Each stage uses only two adder/subtractors and has no angle path. The output is not gain compensated.

Top module: `givens_cordic`

## Requirements
- R1: The latency is NUM_STAGES (default 21) clock cycles. `out_valid` equals `in_valid` from NUM_STAGES cycles earlier, so bubbles keep their position in the stream.
- R2: `out_start` equals `in_start && in_valid` from NUM_STAGES cycles earlier. A start flag on an invalid slot never reaches the output.
- R3: For a start-flagged pair (x ≥ 0), |out_y| < 64. `out_x` is within 64 LSB of 1.6467602·sqrt(x²+y²).
- R4: Stage k (k = 0 … NUM_STAGES-1) handles a start-flagged pair by the sign of its incoming y.
  - If y ≥ 0: x' = x + (y >>> k) and y' = y − (x >>> k). It stores direction bit 0.
  - If y < 0: x' = x − (y >>> k) and y' = y + (x >>> k). It stores direction bit 1.
  - The shifts are arithmetic. The results wrap at DATA_W+2 bits.
- R5: A valid pair without the start flag uses the direction bit stored in each stage, with the same two equations as R4.
- R6: A slot with `in_valid` low does not change any stored direction bit, even when `in_start` is high. The valid pairs that follow are rotated exactly as if the bubble were absent.
- R7: Each new start-flagged valid pair replaces all stored direction bits. This includes start flags on back-to-back cycles.
- R8: Reset clears every stage to zero: data, valid, start and a direction bit of 0. While reset is held, the outputs are zero. Non-start pairs sent right after reset rotate with direction 0 in every stage.
- R9: The inputs are sign-extended to DATA_W+2 bits before the first stage. Full-scale inputs of either sign produce no wrap-around.
- R10: For a start-flagged pair with x ≥ 0, x never decreases from one stage to the next, and `out_x` is non-negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Element pair present this cycle |
| in_start | input | 1 | Pair to be nullified; latches new directions |
| in_x | input | DATA_W | Element from the pivot row (signed) |
| in_y | input | DATA_W | Element from the row being reduced (signed) |
| out_valid | output | 1 | Delayed valid |
| out_start | output | 1 | Delayed start, qualified by valid |
| out_x | output | DATA_W+2 | Rotated pivot-row element (signed) |
| out_y | output | DATA_W+2 | Rotated reduced-row element (signed) |

## Verification
The stage and output assertions assume that a start-flagged pair has a non-negative x element. Under that condition the vectoring iterations converge, x grows at every stage, and the residual y is small. The random stimulus draws every start pair's x from 0 to 32767 and lets y take any 16-bit value. Pairs that follow a start, and slots marked invalid, may use any value in either lane. The directed cases cover zero pairs, full-scale negative y, pure-y vectors and back-to-back starts.

// File: rtl/givens_cordic_pkg.sv
package givens_cordic_pkg;

    // Extra integer bits so that the CORDIC gain cannot overflow the datapath
    localparam int GUARD_BITS = 2;

    // Direction of one micro-rotation
    typedef enum logic {
        ROT_PULL_Y_DOWN = 1'b0,   // y >= 0 : x += y>>>k, y -= x>>>k
        ROT_PUSH_Y_UP   = 1'b1    // y <  0 : x -= y>>>k, y += x>>>k
    } rot_dir_e;

endpackage

// File: rtl/givens_cordic_stage.sv
module givens_cordic_stage
    import givens_cordic_pkg::*;
#(
    parameter int IW    = 18,
    parameter int SHIFT = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_i,
    input  logic                 start_i,
    input  logic signed [IW-1:0] x_i,
    input  logic signed [IW-1:0] y_i,
    output logic                 valid_o,
    output logic                 start_o,
    output logic signed [IW-1:0] x_o,
    output logic signed [IW-1:0] y_o
);

    typedef struct packed {
        logic                 valid;
        logic                 start;
        rot_dir_e             dir;
        logic signed [IW-1:0] x;
        logic signed [IW-1:0] y;
    } stage_t;

    stage_t st_d, st_q;

    logic                 vector_d;
    rot_dir_e             dir_use_d;
    logic signed [IW-1:0] x_sh_d;
    logic signed [IW-1:0] y_sh_d;

    always_comb begin
        st_d      = st_q;
        vector_d  = valid_i && start_i;
        dir_use_d = vector_d ? (y_i[IW-1] ? ROT_PUSH_Y_UP : ROT_PULL_Y_DOWN)
                             : st_q.dir;
        x_sh_d    = x_i >>> SHIFT;
        y_sh_d    = y_i >>> SHIFT;

        st_d.valid = valid_i;
        st_d.start = vector_d;
        if (vector_d) begin
            st_d.dir = dir_use_d;
        end

        // exactly two adder/subtractors per stage
        if (dir_use_d == ROT_PULL_Y_DOWN) begin
            st_d.x = x_i + y_sh_d;
            st_d.y = y_i - x_sh_d;
        end else begin
            st_d.x = x_i - y_sh_d;
            st_d.y = y_i + x_sh_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign start_o = st_q.start;
    assign x_o     = st_q.x;
    assign y_o     = st_q.y;

    AST_X_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && start_i && !x_i[IW-1]) |=> (x_o >= $past(x_i))); // R10

    AST_Y_PULLED_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && start_i && !x_i[IW-1] && !y_i[IW-1]) |=> (y_o <= $past(y_i))); // R4

endmodule

// File: rtl/givens_cordic.sv
module givens_cordic
    import givens_cordic_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int NUM_STAGES = 21
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic                          in_start,
    input  logic signed [DATA_W-1:0]      in_x,
    input  logic signed [DATA_W-1:0]      in_y,
    output logic                          out_valid,
    output logic                          out_start,
    output logic signed [DATA_W+GUARD_BITS-1:0] out_x,
    output logic signed [DATA_W+GUARD_BITS-1:0] out_y
);

    localparam int IW          = DATA_W + GUARD_BITS;
    localparam int RESID_LIMIT = 1 << (GUARD_BITS + 4);

    logic                 v_w [0:NUM_STAGES];
    logic                 s_w [0:NUM_STAGES];
    logic signed [IW-1:0] x_w [0:NUM_STAGES];
    logic signed [IW-1:0] y_w [0:NUM_STAGES];

    // sign extension into the guarded datapath
    assign v_w[0] = in_valid;
    assign s_w[0] = in_start;
    assign x_w[0] = IW'(in_x);
    assign y_w[0] = IW'(in_y);

    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
        givens_cordic_stage #(
            .IW    (IW),
            .SHIFT (k)
        ) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .valid_i (v_w[k]),
            .start_i (s_w[k]),
            .x_i     (x_w[k]),
            .y_i     (y_w[k]),
            .valid_o (v_w[k+1]),
            .start_o (s_w[k+1]),
            .x_o     (x_w[k+1]),
            .y_o     (y_w[k+1])
        );
    end

    assign out_valid = v_w[NUM_STAGES];
    assign out_start = s_w[NUM_STAGES];
    assign out_x     = x_w[NUM_STAGES];
    assign out_y     = y_w[NUM_STAGES];

    AST_Y_NULLED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_start) |-> ((out_y < RESID_LIMIT) && (out_y > -RESID_LIMIT))); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_start) |-> !out_x[IW-1]); // R10

endmodule

// File: tb/givens_cordic_bench.sv
module givens_cordic_bench;

    localparam int DATA_W = 16;
    localparam int NS     = 21;
    localparam int IW     = DATA_W + 2;
    localparam int RING   = 32;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     in_valid = 1'b0;
    logic                     in_start = 1'b0;
    logic signed [DATA_W-1:0] in_x = '0;
    logic signed [DATA_W-1:0] in_y = '0;
    logic                     out_valid;
    logic                     out_start;
    logic signed [IW-1:0]     out_x;
    logic signed [IW-1:0]     out_y;

    always #2ns clk = ~clk;   // 250 MHz

    givens_cordic #(.DATA_W(DATA_W), .NUM_STAGES(NS)) u_givens_cordic (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .in_x(in_x), .in_y(in_y), .out_valid(out_valid), .out_start(out_start),
        .out_x(out_x), .out_y(out_y)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int wd     = 0;

    bit mdir [NS];

    bit                   e_valid [RING];
    bit                   e_start [RING];
    logic signed [IW-1:0] e_x     [RING];
    logic signed [IW-1:0] e_y     [RING];
    int                   e_ax    [RING];
    int                   e_ay    [RING];
    string                e_tag   [RING];

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Reference rotation built from the requirement equations
    task automatic model(input bit s, input int xi, input int yi,
                         output logic signed [IW-1:0] xo, output logic signed [IW-1:0] yo);
        logic signed [IW-1:0] x, y, xn, yn;
        x = IW'(xi);
        y = IW'(yi);
        for (int k = 0; k < NS; k++) begin
            bit d;
            d = s ? y[IW-1] : mdir[k];
            if (s) mdir[k] = d;
            if (!d) begin
                xn = x + (y >>> k);
                yn = y - (x >>> k);
            end else begin
                xn = x - (y >>> k);
                yn = y + (x >>> k);
            end
            x = xn;
            y = yn;
        end
        xo = x;
        yo = y;
    endtask

    function automatic int rs16();
        logic [15:0] r;
        r = 16'($urandom);
        return int'($signed(r));
    endfunction

    // one cycle: check what leaves now, then drive the next pair
    task automatic step(input bit v, input bit s, input int xv, input int yv, input string tag);
        int rd, wr;
        logic signed [IW-1:0] ex, ey;
        rd = (cyc + RING - NS) % RING;
        wr = cyc % RING;
        chk(out_valid == e_valid[rd], "R1", "out_valid", out_valid, e_valid[rd]);
        chk(out_start == e_start[rd], "R2", "out_start", out_start, e_start[rd]);
        if (e_valid[rd]) begin
            chk(out_x == e_x[rd], e_tag[rd], "out_x", out_x, e_x[rd]);
            chk(out_y == e_y[rd], e_tag[rd], "out_y", out_y, e_y[rd]);
        end
        if (e_valid[rd] && e_start[rd]) begin
            real mag;
            mag = 1.6467602 * $sqrt(real'(e_ax[rd]) * e_ax[rd] + real'(e_ay[rd]) * e_ay[rd]);
            chk((out_y < 64) && (out_y > -64), "R3", "residual y", out_y, 0);
            chk(((real'(out_x) - mag) < 64.0) && ((mag - real'(out_x)) < 64.0),
                "R3", "scaled magnitude", out_x, longint'(mag));
            chk(!out_x[IW-1], "R10", "x sign", out_x, 0);
        end
        e_valid[wr] = v;
        e_start[wr] = v && s;
        e_ax[wr]    = xv;
        e_ay[wr]    = yv;
        e_tag[wr]   = (v && s) ? "R4" : tag;
        if (v) begin
            model(s, xv, yv, ex, ey);
            e_x[wr] = ex;
            e_y[wr] = ey;
        end
        in_valid = v;
        in_start = s;
        in_x     = DATA_W'(xv);
        in_y     = DATA_W'(yv);
        @(posedge clk);
        @(negedge clk);
        cyc++;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            fails++;
            $display("FAIL R1 watchdog: actual %0d cycles expected < 100000", wd);
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < RING; i++) begin
            e_valid[i] = 1'b0; e_start[i] = 1'b0; e_x[i] = '0; e_y[i] = '0;
            e_ax[i] = 0; e_ay[i] = 0; e_tag[i] = "R8";
        end
        for (int i = 0; i < NS; i++) mdir[i] = 1'b0;

        // R8: hold reset with active inputs, outputs must stay zero
        in_valid = 1'b1; in_start = 1'b1; in_x = 16'sd1234; in_y = -16'sd999;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!out_valid && !out_start, "R8", "valid/start in reset", {out_valid, out_start}, 0);
        chk(out_x == 0 && out_y == 0, "R8", "data in reset", out_x, 0);
        rst_n = 1'b1;

        // R8: non-start pairs right after reset use direction 0 everywhere
        step(1, 0, 1000, 2000, "R8");
        step(1, 0, -3000, 500, "R8");

        // R9: full-scale values, sign extension
        step(1, 1, 32767, -32768, "R9");
        step(1, 0, -32768, -32768, "R9");
        step(1, 0, 32767, 32767, "R9");
        // R4 corners: zero pair, pure +y, pure -y, y = 0
        step(1, 1, 0, 0, "R4");
        step(1, 1, 0, 20000, "R4");
        step(1, 1, 0, -32768, "R4");
        step(1, 1, 25000, 0, "R4");
        step(1, 0, 123, -456, "R5");

        // R6: bubble carrying a start flag and garbage data
        step(1, 1, 5000, -7000, "R6");
        step(0, 1, -11111, 22222, "R6");
        step(1, 0, 3000, 4000, "R6");
        step(0, 0, 999, 999, "R6");
        step(1, 0, -2500, 1200, "R6");

        // R7: back-to-back starts, then a replay on the last one
        step(1, 1, 100, 30000, "R7");
        step(1, 1, 30000, -100, "R7");
        step(1, 1, 7, -7, "R7");
        step(1, 0, 8000, 8000, "R7");
        step(1, 0, -8000, 100, "R7");

        // R5: random row pairs with random bubbles
        for (int r = 0; r < 300; r++) begin
            int len;
            len = 1 + int'($urandom % 6);
            step(1, 1, int'($urandom % 32768), rs16(), "R5");
            for (int e = 1; e < len; e++) begin
                if ($urandom % 5 == 0)
                    step(0, 1'($urandom), rs16(), rs16(), "R6");
                step(1, 0, rs16(), rs16(), "R5");
            end
        end

        // drain
        for (int i = 0; i < NS + 4; i++) step(0, 0, 0, 0, "R1");

        summary();
        $finish;
    end

endmodule